// File: doc/BRIEF.md
# Data-Phase Timeout Watchdog with Kilocycle Prescale

This block guards the data phase of a memory-card host controller. When the host starts waiting for a data block, it pulses `arm`. The block then counts card-clock cycles, qualified by the `tick` enable strobe, down from a 16-bit limit. If the card neither delivers nor finishes the block before the limit runs out, the sticky `expired` flag rises. Software clears that flag through its status path with `flag_clr`.

A mode input, sampled at `arm`, picks the counting unit:

- **Single-cycle mode:** every tick counts.
- **Kilocycle mode:** a 10-bit prescaler divides the ticks by 1024 before they reach the main count. This lets a long wait be expressed as `(cycles >> 10) + 1` in 16 bits.

A loaded limit of zero gives an unlimited wait. The block stays running but never expires.

A `halt` pulse ends the wait quietly when data arrives or the block completes. An `abort` pulse returns everything to idle. The outputs `running` and `remaining` expose the wait state and the current main count.

Top module: `dto_watch`

## Requirements
- R1: After reset, `expired` is 0, `running` is 0 and `remaining` is 0.
- R2: A cycle with `arm`=1 (and `abort`=0) sets `running` to 1, loads `remaining` with `cfg_limit` and restarts the prescaler. Any `tick` or `halt` in that same cycle is ignored.
- R3: With `cfg_kilo`=0 at arm time, each cycle with `tick`=1 while running lowers `remaining` by 1. For a limit N, `expired` rises on exactly the Nth such tick after arm.
- R4: With `cfg_kilo`=1 at arm time, `remaining` drops by 1 once every 1024 ticks. For a limit N, `expired` rises on tick N*1024 and not on tick N*1024-1.
- R5: Cycles with `tick`=0 leave `remaining` and the prescaler unchanged.
- R6: Arming with `cfg_limit`=0 keeps `running` at 1 and `remaining` at 0, and `expired` never rises, however many ticks arrive.
- R7: A cycle with `halt`=1 (and neither `arm` nor `abort`) clears `running`, freezes `remaining`, and does not set `expired`. Later ticks have no effect until the next arm.
- R8: On expiry, `expired` becomes 1 and `running` becomes 0 in the same cycle. `expired` then holds until a `flag_clr` cycle. If expiry and `flag_clr` fall in the same cycle, the flag ends set. A new `arm` does not clear it.
- R9: A cycle with `abort`=1 overrides every other input. It clears `running`, `remaining` and `expired`.
- R10: `cfg_limit` and `cfg_kilo` are used only at arm time. Changing them while running has no effect on the wait in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Card-clock enable strobe; one count per high cycle |
| cfg_limit | input | 16 | Timeout limit, sampled at arm; 0 means unlimited |
| cfg_kilo | input | 1 | Unit select sampled at arm: 0 single cycles, 1 kilocycles |
| arm | input | 1 | Start pulse: begin a new wait |
| halt | input | 1 | Data received or block done: stop without flagging |
| abort | input | 1 | Abort pulse: return to idle and clear the flag |
| flag_clr | input | 1 | Clear the sticky timeout flag |
| expired | output | 1 | Sticky data-timeout flag |
| running | output | 1 | A wait is in progress |
| remaining | output | 16 | Current main count |

## Verification
A wrong main count or mode shows at `remaining` on the very cycle after the offending tick. A prescaler that wraps at the wrong value only becomes visible at the 1024th tick. For that reason the kilocycle test samples `remaining` on both sides of that boundary and checks expiry on the exact last tick. A control state stuck in the unlimited or idle state shows as a `running` value that disagrees with the arm and halt history, one cycle after the pulse. Lost flag priority shows as an `expired` that drops on a cycle that also carried an expiry.

// File: rtl/dto_pkg.sv
// Package: shared types for the data-phase timeout watchdog.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package dto_pkg;

    // Counting unit selected at arm time
    typedef enum logic {
        UNIT_CYCLE = 1'b0,
        UNIT_KILO  = 1'b1
    } dto_unit_e;

    // Wait state of the watchdog
    typedef enum logic [1:0] {
        WAIT_IDLE  = 2'd0,
        WAIT_TIMED = 2'd1,
        WAIT_FREE  = 2'd2
    } dto_wait_e;

endpackage

// File: rtl/dto_seq.sv
// Module: dto_seq
// Wait-state sequencer. Decides when the watchdog is counting, latches the
// counting unit at arm, and owns the sticky expiry flag.
// Assumes: arm, halt and abort are single-cycle pulses; abort beats arm,
// arm beats halt, halt beats tick.
module dto_seq
    import dto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm,
    input  logic halt,
    input  logic abort,
    input  logic flag_clr,
    input  logic limit_zero,
    input  logic unit_in,
    input  logic last_step,
    output logic do_load,
    output logic do_clear,
    output logic do_step,
    output logic unit_kilo,
    output logic running,
    output logic expired
);

    dto_wait_e state_q;
    dto_wait_e state_d;
    dto_unit_e unit_q;
    logic      flag_q;

    // Command decode with fixed priority
    always_comb begin
        do_clear = abort;
        do_load  = arm && !abort;
        do_step  = (state_q == WAIT_TIMED) && tick && !arm && !halt && !abort;
    end

    // Next wait state
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = WAIT_IDLE;
        end else if (arm) begin
            state_d = limit_zero ? WAIT_FREE : WAIT_TIMED;
        end else if (halt) begin
            state_d = WAIT_IDLE;
        end else if (last_step) begin
            state_d = WAIT_IDLE;
        end
    end

    // Wait state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WAIT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counting unit latched on arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_q <= UNIT_CYCLE;
        end else if (do_load) begin
            unit_q <= dto_unit_e'(unit_in);
        end
    end

    // Sticky flag: abort clears, expiry sets over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (abort) begin
            flag_q <= 1'b0;
        end else if (last_step) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign unit_kilo = (unit_q == UNIT_KILO);
    assign running   = (state_q != WAIT_IDLE);
    assign expired   = flag_q;

endmodule

// File: rtl/dto_prescale.sv
// Module: dto_prescale
// Divides qualified ticks by 2**PRE_W in kilocycle mode; passes every tick
// in single-cycle mode.
// Assumes: clear and load restart the divider; step is already qualified.
module dto_prescale #(
    parameter int PRE_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    input  logic kilo,
    output logic carry
);

    localparam logic [PRE_W-1:0] PRE_TOP = {PRE_W{1'b1}};

    logic [PRE_W-1:0] div_q;

    // Divider register: wraps from PRE_TOP to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (step && kilo) begin
            div_q <= div_q + 1'b1;
        end
    end

    // Carry toward the main count
    always_comb begin
        carry = step && (!kilo || (div_q == PRE_TOP));
    end

endmodule

// File: rtl/dto_count.sv
// Module: dto_count
// Main down-counter. Loads the limit at arm and steps down on each
// prescaler carry. Flags the step that takes it from one to zero.
// Assumes: dec is never raised for a zero count by the sequencer.
module dto_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] value,
    output logic             last_step
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Terminal step detect
    always_comb begin
        last_step = dec && (cnt_q == ONE);
    end

    assign value = cnt_q;

endmodule

// File: rtl/dto_watch.sv
// Module: dto_watch (top)
// Data-phase timeout watchdog. Counts qualified card-clock ticks after an
// arm pulse and raises a sticky flag when the loaded limit runs out.
// Assumes: tick is a one-cycle enable in the clk domain; all inputs are
// synchronous to clk.
module dto_watch #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic             cfg_kilo,
    input  logic             arm,
    input  logic             halt,
    input  logic             abort,
    input  logic             flag_clr,
    output logic             expired,
    output logic             running,
    output logic [CNT_W-1:0] remaining
);

    logic do_load;
    logic do_clear;
    logic do_step;
    logic unit_kilo;
    logic carry;
    logic last_step;
    logic limit_zero;

    assign limit_zero = (cfg_limit == '0);

    dto_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .arm        (arm),
        .halt       (halt),
        .abort      (abort),
        .flag_clr   (flag_clr),
        .limit_zero (limit_zero),
        .unit_in    (cfg_kilo),
        .last_step  (last_step),
        .do_load    (do_load),
        .do_clear   (do_clear),
        .do_step    (do_step),
        .unit_kilo  (unit_kilo),
        .running    (running),
        .expired    (expired)
    );

    dto_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_load || do_clear),
        .step    (do_step),
        .kilo    (unit_kilo),
        .carry   (carry)
    );

    dto_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_clear),
        .load      (do_load),
        .load_val  (cfg_limit),
        .dec       (carry),
        .value     (remaining),
        .last_step (last_step)
    );

endmodule

// File: rtl/dto_watch_checker.sv
// Module: dto_watch_checker
// Port-level properties of the timeout watchdog, bound to dto_watch.
module dto_watch_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] cfg_limit,
    input logic             arm,
    input logic             halt,
    input logic             abort,
    input logic             flag_clr,
    input logic             expired,
    input logic             running,
    input logic [CNT_W-1:0] remaining
);

    assert_arm_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !abort) |=> (running && remaining == $past(cfg_limit)));

    assert_idle_tick_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !arm && !abort) |=> $stable(remaining));

    assert_zero_no_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && remaining == '0 && !arm && !abort) |=> !$rose(expired));

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !arm && !abort) |=> (!running && $stable(remaining) && !$rose(expired)));

    assert_expiry_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> !running);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !flag_clr && !abort) |=> expired);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!running && !expired && remaining == '0));

endmodule

bind dto_watch dto_watch_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dto_watch_bench.sv
module dto_watch_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cfg_limit = '0;
    logic        cfg_kilo = 1'b0;
    logic        arm = 1'b0;
    logic        halt = 1'b0;
    logic        abort = 1'b0;
    logic        flag_clr = 1'b0;
    logic        expired;
    logic        running;
    logic [15:0] remaining;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dto_watch u_dto_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg_limit (cfg_limit),
        .cfg_kilo  (cfg_kilo),
        .arm       (arm),
        .halt      (halt),
        .abort     (abort),
        .flag_clr  (flag_clr),
        .expired   (expired),
        .running   (running),
        .remaining (remaining)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock with the given pulses; outputs sampled at the following negedge
    task automatic cyc(input logic t, input logic a = 0, input logic h = 0,
                       input logic ab = 0, input logic fc = 0);
        tick = t; arm = a; halt = h; abort = ab; flag_clr = fc;
        @(posedge clk);
        @(negedge clk);
        tick = 0; arm = 0; halt = 0; abort = 0; flag_clr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1);
    endtask

    task automatic do_arm(input int lim, input logic kilo);
        cfg_limit = 16'(lim);
        cfg_kilo  = kilo;
        cyc(0, 1);
    endtask

    task automatic t_reset;
        chk("R1 expired", expired, 0);
        chk("R1 running", running, 0);
        chk("R1 remaining", remaining, 0);
    endtask

    task automatic t_cycle_mode;
        do_arm(5, 0);
        chk("R2 running", running, 1);
        chk("R2 remaining", remaining, 5);
        ticks(4);
        chk("R3 remaining", remaining, 1);
        chk("R3 not yet", expired, 0);
        ticks(1);
        chk("R8 expired", expired, 1);
        chk("R8 running", running, 0);
        cyc(0); cyc(1); cyc(0);
        chk("R8 sticky", expired, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R8 cleared", expired, 0);
    endtask

    task automatic t_gaps;
        do_arm(4, 0);
        cyc(0); cyc(0); cyc(0);
        chk("R5 gap hold", remaining, 4);
        cyc(1);
        chk("R5 tick after gap", remaining, 3);
        cyc(0, 0, 0, 1);
    endtask

    task automatic t_kilo_mode;
        do_arm(2, 1);
        ticks(1023);
        chk("R4 before wrap", remaining, 2);
        ticks(1);
        chk("R4 after wrap", remaining, 1);
        ticks(1023);
        chk("R4 one short", expired, 0);
        ticks(1);
        chk("R4 expired", expired, 1);
        cyc(0, 0, 0, 0, 1);
    endtask

    task automatic t_unlimited;
        do_arm(0, 0);
        ticks(3000);
        chk("R6 running", running, 1);
        chk("R6 expired", expired, 0);
        chk("R6 remaining", remaining, 0);
        cyc(0, 0, 1);
        chk("R7 halt free wait", running, 0);
    endtask

    task automatic t_halt;
        do_arm(10, 0);
        ticks(3);
        cyc(1, 0, 1);
        chk("R7 running", running, 0);
        chk("R7 frozen", remaining, 7);
        chk("R7 no flag", expired, 0);
        ticks(12);
        chk("R7 ignored ticks", remaining, 7);
        chk("R7 still no flag", expired, 0);
    endtask

    task automatic t_abort;
        do_arm(3, 0);
        ticks(3);
        chk("R8 expiry before rearm", expired, 1);
        do_arm(6, 0);
        chk("R8 rearm keeps flag", expired, 1);
        chk("R2 rearm value", remaining, 6);
        cyc(1, 1, 0, 1);
        chk("R9 running", running, 0);
        chk("R9 expired", expired, 0);
        chk("R9 remaining", remaining, 0);
    endtask

    task automatic t_latch;
        do_arm(3, 0);
        cfg_kilo = 1;
        cfg_limit = 16'd100;
        ticks(2);
        chk("R10 remaining", remaining, 1);
        ticks(1);
        chk("R10 expired", expired, 1);
        cyc(0, 0, 0, 0, 1);
    endtask

    task automatic t_priority;
        cfg_limit = 16'd9; cfg_kilo = 0;
        cyc(1, 1, 1);
        chk("R2 arm over tick", remaining, 9);
        chk("R2 arm over halt", running, 1);
        cfg_limit = 16'd1;
        cyc(0, 1);
        cyc(1, 0, 0, 0, 1);
        chk("R8 set beats clear", expired, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R8 clear later", expired, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cycle_mode();
        t_gaps();
        t_kilo_mode();
        t_unlimited();
        t_halt();
        t_abort();
        t_latch();
        t_priority();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule